// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block is a direct-mapped data cache that sits between a byte-wide processor request port and a memory port that moves whole blocks. Each line holds a valid flag, a dirty flag, a stored tag and one data block. A request address is cut into a tag, a line index and a byte offset. One line is looked up, and the valid flag and the tag comparison together decide hit or miss.

On a miss the controller first writes a dirty victim back to memory, then fetches the new block, then replays the request, which now hits. A write that misses therefore allocates the block, and only after the fill does it merge its byte and mark the line dirty. Write hits stay in the cache until the line is evicted.

The controller runs as four named states:
- `ST_IDLE` accepts a request.
- `ST_LOOKUP` decides hit or miss.
- `ST_WRBACK` drives the victim block to memory.
- `ST_FILL` reads the new block.

The transitions are:
- IDLE→LOOKUP when a request is accepted.
- LOOKUP→IDLE on a hit.
- LOOKUP→WRBACK on a miss to a dirty valid line.
- LOOKUP→FILL on a miss to a clean or invalid line.
- WRBACK→FILL on acknowledge.
- FILL→LOOKUP on acknowledge, which replays the request.

Top module: `dcache_dm_ctrl`

## Requirements
- R1: The request address is split with the lowest OFF_W bits as byte offset, the next IDX_W bits as line index and the remaining high bits as tag. Every memory-port address is block aligned (offset bits zero).
- R2: A read hit presents `cpu_rvalid` high with the addressed byte on `cpu_rdata` in the cycle right after acceptance, and makes no memory request.
- R3: A line whose stored tag equals the request tag but whose valid flag is clear is a miss and is refilled from memory.
- R4: A miss to a clean or invalid line issues exactly one memory read (`mem_we`=0) of the block-aligned request address and no memory write.
- R5: A miss to a dirty valid line first issues one memory write (`mem_we`=1) at address {stored tag, index, zero offset} carrying the whole stored block. Only after its acknowledge does it issue the read of the new block. Request, address and direction stay stable until acknowledge.
- R6: A fill replaces the whole block, the tag and sets valid, so any other byte of that block then hits without memory traffic.
- R7: A write hit changes only the addressed byte in the cache, sets dirty and makes no memory request.
- R8: A write miss fetches the block, then merges the written byte and sets dirty. The merged byte reaches memory when the line is later evicted.
- R9: `cpu_ready` is high only in the idle state. It drops in the cycle after acceptance and stays low while any memory request is active.
- R10: Synchronous reset clears every valid and dirty flag, so no line written before reset is ever written back after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | Read data valid |
| mem_req | output | 1 | Memory request active |
| mem_we | output | 1 | 1 = block write-back, 0 = block fill |
| mem_addr | output | ADDR_W | Block-aligned memory address |
| mem_wdata | output | 8<<OFF_W | Victim block for write-back |
| mem_rdata | input | 8<<OFF_W | Fill block, sampled on acknowledge |
| mem_ack | input | 1 | Memory completes the request |

## Verification
The bench builds the controller with a 16-bit address, a 4-bit index and a 3-bit offset. This leaves a 9-bit tag and sixteen lines of eight bytes. With that shape, conflicting blocks sit only 128 bytes apart, so dirty evictions, replays after write misses and hits on the first and last index all fit in a short sequence. The backing memory model also stays small. A tag value still present after reset, with its valid flag cleared, makes the matching-tag-but-invalid case directly reachable.

// File: rtl/dcache_dm_pkg.sv
package dcache_dm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_WRBACK = 2'd2,
        ST_FILL   = 2'd3
    } dc_state_e;

endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store #(
    parameter int IDX_W = 10,
    parameter int TAG_W = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_dirty
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // flags are reset, tags are not
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/dcache_data_store.sv
module dcache_data_store #(
    parameter int IDX_W = 10,
    parameter int BLK_W = 64
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [BLK_W-1:0] rd_block,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [BLK_W-1:0] wr_block
);
    localparam int LINES = 1 << IDX_W;

    logic [BLK_W-1:0] blk_q [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            blk_q[wr_idx] <= wr_block;
        end
    end

    assign rd_block = blk_q[rd_idx];

endmodule

// File: rtl/dcache_byte_lane.sv
module dcache_byte_lane #(
    parameter int OFF_W = 3
) (
    input  logic [(8<<OFF_W)-1:0] blk_in,
    input  logic [OFF_W-1:0]      off,
    input  logic [7:0]            wbyte,
    output logic [7:0]            rbyte,
    output logic [(8<<OFF_W)-1:0] blk_merged
);
    localparam int NBYTES = 1 << OFF_W;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign blk_merged[8*g +: 8] = (off == OFF_W'(g)) ? wbyte : blk_in[8*g +: 8];
    end

    assign rbyte = blk_in[8*off +: 8];

endmodule

// File: rtl/dcache_dm_ctrl.sv
module dcache_dm_ctrl
    import dcache_dm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cpu_valid,
    output logic                   cpu_ready,
    input  logic                   cpu_we,
    input  logic [ADDR_W-1:0]      cpu_addr,
    input  logic [7:0]             cpu_wdata,
    output logic [7:0]             cpu_rdata,
    output logic                   cpu_rvalid,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [(8<<OFF_W)-1:0]  mem_wdata,
    input  logic [(8<<OFF_W)-1:0]  mem_rdata,
    input  logic                   mem_ack
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int BLK_W = 8 << OFF_W;

    dc_state_e         state_q, state_d;
    logic [ADDR_W-1:0] req_addr_q;
    logic              req_we_q;
    logic [7:0]        req_wdata_q;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [OFF_W-1:0]  req_off;

    logic              line_valid, line_dirty, hit;
    logic [TAG_W-1:0]  line_tag;
    logic [BLK_W-1:0]  line_blk, merged_blk;
    logic [7:0]        sel_byte;

    logic              tag_wr, tag_wr_dirty;
    logic              data_wr;
    logic [BLK_W-1:0]  data_wr_blk;

    // address split: offset low, index middle, tag high
    assign req_off = req_addr_q[OFF_W-1:0];
    assign req_idx = req_addr_q[OFF_W +: IDX_W];
    assign req_tag = req_addr_q[ADDR_W-1 -: TAG_W];

    dcache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (req_idx),
        .rd_valid (line_valid),
        .rd_dirty (line_dirty),
        .rd_tag   (line_tag),
        .wr_en    (tag_wr),
        .wr_idx   (req_idx),
        .wr_tag   (req_tag),
        .wr_dirty (tag_wr_dirty)
    );

    dcache_data_store #(.IDX_W(IDX_W), .BLK_W(BLK_W)) u_data (
        .clk      (clk),
        .rd_idx   (req_idx),
        .rd_block (line_blk),
        .wr_en    (data_wr),
        .wr_idx   (req_idx),
        .wr_block (data_wr_blk)
    );

    dcache_byte_lane #(.OFF_W(OFF_W)) u_lane (
        .blk_in     (line_blk),
        .off        (req_off),
        .wbyte      (req_wdata_q),
        .rbyte      (sel_byte),
        .blk_merged (merged_blk)
    );

    // valid and tag compare evaluated together
    assign hit = line_valid && (line_tag == req_tag);

    // state register and request capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (state_q == ST_IDLE && cpu_valid) begin
            req_addr_q  <= cpu_addr;
            req_we_q    <= cpu_we;
            req_wdata_q <= cpu_wdata;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cpu_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (hit)                           state_d = ST_IDLE;
                else if (line_valid && line_dirty) state_d = ST_WRBACK;
                else                               state_d = ST_FILL;
            end
            ST_WRBACK: if (mem_ack) state_d = ST_FILL;
            ST_FILL:   if (mem_ack) state_d = ST_LOOKUP;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs and array write strobes
    always_comb begin
        cpu_ready    = 1'b0;
        cpu_rvalid   = 1'b0;
        cpu_rdata    = sel_byte;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = {req_tag, req_idx, {OFF_W{1'b0}}};
        mem_wdata    = line_blk;
        tag_wr       = 1'b0;
        tag_wr_dirty = 1'b0;
        data_wr      = 1'b0;
        data_wr_blk  = merged_blk;
        unique case (state_q)
            ST_IDLE: cpu_ready = 1'b1;
            ST_LOOKUP: begin
                if (hit && !req_we_q) begin
                    cpu_rvalid = 1'b1;
                end
                if (hit && req_we_q) begin
                    tag_wr       = 1'b1;
                    tag_wr_dirty = 1'b1;
                    data_wr      = 1'b1;
                    data_wr_blk  = merged_blk;
                end
            end
            ST_WRBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {line_tag, req_idx, {OFF_W{1'b0}}};
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    tag_wr       = 1'b1;
                    tag_wr_dirty = 1'b0;
                    data_wr      = 1'b1;
                    data_wr_blk  = mem_rdata;
                end
            end
            default: cpu_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/dcache_dm_ctrl_chk.sv
module dcache_dm_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_valid,
    input logic              cpu_ready,
    input logic              cpu_rvalid,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);
    // R1: memory traffic is block aligned
    p_block_align_r1: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    // R2: read data never coincides with memory traffic
    p_rvalid_no_mem_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_rvalid |-> !mem_req);

    // R5: request held steady until acknowledged
    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5: write-back is followed directly by a fill
    p_wb_then_fill_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    // R6: after a fill the request is replayed without memory traffic
    p_fill_replay_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ack) |=> (!mem_req && !cpu_ready));

    // R9: ready excludes memory activity and read data
    p_ready_idle_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> (!mem_req && !cpu_rvalid));

    // R9: acceptance drops ready on the next cycle
    p_accept_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_ready) |=> !cpu_ready);

endmodule

bind dcache_dm_ctrl dcache_dm_ctrl_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_valid  (cpu_valid),
    .cpu_ready  (cpu_ready),
    .cpu_rvalid (cpu_rvalid),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack)
);

// File: tb/dcache_dm_ctrl_tb.sv
module dcache_dm_ctrl_tb;
    localparam int AW = 16;
    localparam int IW = 4;
    localparam int OW = 3;
    localparam int BW = 8 << OW;
    localparam int NV = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_valid = 1'b0;
    logic          cpu_ready;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0]    cpu_wdata = '0;
    logic [7:0]    cpu_rdata;
    logic          cpu_rvalid;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [BW-1:0] mem_wdata;
    logic [BW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;

    always #2.5 clk = ~clk;

    dcache_dm_ctrl #(.ADDR_W(AW), .IDX_W(IW), .OFF_W(OW)) u_dut (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // backing memory: byte at a = a[7:0] ^ 8'hA5; blocks keyed by addr[8:3]
    logic [BW-1:0] mem_blk [64];
    int            wb_cnt, fill_cnt, lat_cnt;
    logic [AW-1:0] wb_addr;

    initial begin
        for (int b = 0; b < 64; b++) begin
            for (int k = 0; k < 8; k++) begin
                mem_blk[b][8*k +: 8] = 8'((b * 8 + k) & 255) ^ 8'hA5;
            end
        end
    end

    always @(negedge clk) begin
        if (rst || mem_ack) begin
            mem_ack = 1'b0;
            lat_cnt = 0;
        end else if (mem_req) begin
            lat_cnt++;
            if (lat_cnt == 2) begin
                lat_cnt = 0;
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem_blk[mem_addr[8:3]] = mem_wdata;
                    wb_cnt++;
                    wb_addr = mem_addr;
                end else begin
                    mem_rdata = mem_blk[mem_addr[8:3]];
                    fill_cnt++;
                end
            end
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-op observations
    logic [7:0] got_rd;
    int         got_lat;
    bit         busy_ready;
    bit         first_low;

    task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [7:0] d);
        int cyc;
        wb_cnt = 0; fill_cnt = 0; wb_addr = '0;
        got_rd = 8'h00; got_lat = 0; busy_ready = 0;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cpu_valid = 1'b0;
        first_low = !cpu_ready;
        cyc = 1;
        while (!cpu_ready && cyc < 100) begin
            if (cpu_rvalid) begin
                got_rd = cpu_rdata;
                got_lat = cyc;
            end
            if (mem_req && cpu_ready) busy_ready = 1;
            @(negedge clk);
            cyc++;
        end
    endtask

    // {we, addr, wdata, exp_rdata, exp_wb, exp_fill, exp_wb_addr}
    // R1 split in bench shape: tag=addr[15:7], index=addr[6:3], offset=addr[2:0]
    localparam logic [52:0] VEC [NV] = '{
        {1'b0, 16'h0012, 8'h00, 8'hB7, 2'd0, 2'd1, 16'h0000}, // cold miss
        {1'b0, 16'h0015, 8'h00, 8'hB0, 2'd0, 2'd0, 16'h0000}, // hit other byte
        {1'b1, 16'h0013, 8'h3C, 8'h00, 2'd0, 2'd0, 16'h0000}, // write hit
        {1'b0, 16'h0013, 8'h00, 8'h3C, 2'd0, 2'd0, 16'h0000}, // read back
        {1'b0, 16'h0092, 8'h00, 8'h37, 2'd1, 2'd1, 16'h0010}, // dirty conflict
        {1'b0, 16'h0013, 8'h00, 8'h3C, 2'd0, 2'd1, 16'h0000}, // written-back byte
        {1'b1, 16'h0121, 8'h5A, 8'h00, 2'd0, 2'd1, 16'h0000}, // write miss
        {1'b0, 16'h0120, 8'h00, 8'h85, 2'd0, 2'd0, 16'h0000}, // neighbour byte
        {1'b0, 16'h0121, 8'h00, 8'h5A, 2'd0, 2'd0, 16'h0000}, // merged byte
        {1'b0, 16'h01A7, 8'h00, 8'h02, 2'd1, 2'd1, 16'h0120}, // evict merged
        {1'b0, 16'h0121, 8'h00, 8'h5A, 2'd0, 2'd1, 16'h0000}, // merged in memory
        {1'b0, 16'h007F, 8'h00, 8'hDA, 2'd0, 2'd1, 16'h0000}, // last index, last byte
        {1'b0, 16'h0000, 8'h00, 8'hA5, 2'd0, 2'd1, 16'h0000}  // first index
    };

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(cpu_ready == 1'b1, "R9 ready after reset", cpu_ready, 1);
        chk(mem_req == 1'b0, "R10 no mem request after reset", mem_req, 0);
        chk(cpu_rvalid == 1'b0, "R2 no rvalid after reset", cpu_rvalid, 0);

        for (int i = 0; i < NV; i++) begin
            logic [52:0] v;
            v = VEC[i];
            do_op(v[52], v[51:36], v[35:28]);
            if (!v[52]) begin
                chk(got_rd == v[27:20], "R2/R6/R8 read byte", got_rd, v[27:20]);
            end
            chk(wb_cnt == int'(v[19:18]), "R5/R7 write-back count", wb_cnt, v[19:18]);
            chk(fill_cnt == int'(v[17:16]), "R4/R7/R8 fill count", fill_cnt, v[17:16]);
            if (v[19:18] != 0) begin
                chk(wb_addr == v[15:0], "R5 victim address", wb_addr, v[15:0]);
            end
            if (!v[52] && v[17:16] == 0) begin
                chk(got_lat == 1, "R2 hit latency", got_lat, 1);
            end
            chk(first_low && !busy_ready, "R9 ready low while busy", busy_ready, 0);
        end

        // R10 / R3: dirty line, then reset; tag kept but invalid
        do_op(1'b1, 16'h0014, 8'h77);
        chk(fill_cnt == 0 && wb_cnt == 0, "R7 write hit no traffic", fill_cnt + wb_cnt, 0);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        do_op(1'b0, 16'h0014, 8'h00);
        chk(fill_cnt == 1, "R3 matching tag on invalid line refills", fill_cnt, 1);
        chk(wb_cnt == 0, "R10 dirty cleared by reset", wb_cnt, 0);
        chk(got_rd == 8'hB1, "R10 pre-reset write discarded", got_rd, 8'hB1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule